// File: doc/BRIEF.md
# DRAM ECC Error Logging Registers

This block sits beside the ECC checker of a two-channel DRAM controller and keeps a software-visible record of memory error events. The checker raises a one-cycle event strobe with a flag telling correctable (single-bit) from uncorrectable (multi-bit), the 33-bit physical address, the channel number and the 8-bit syndrome. Three further one-cycle event inputs report a thermal sensor trip, a locked access aimed at non-memory space, and a refresh timeout. Each event sets a sticky flag in a 16-bit status register.

Software reaches the registers through a small port with a 3-bit register index, a write strobe, 16 bits of write data and 32 bits of read data that is combinational on the index. Status flags are cleared by writing ones. A 16-bit command register selects which flags drive a level system-error output. Address, channel and syndrome of one error are held in capture registers. An uncorrectable error replaces the record of an earlier correctable one. A correctable error never replaces anything once an error flag is up.

Register index map: 0 status, 1 command, 2 error address, 3 extended address, 4 syndrome; indices 5 to 7 read zero and ignore writes.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `serr` is low.
- R2: A correctable event (`ev_valid` with `ev_multi`=0) sets status bit 0; an uncorrectable event (`ev_multi`=1) sets status bit 1. The flag reads back from the cycle after the event.
- R3: `ev_refto` sets status bit 8, `ev_lock` sets bit 9 and `ev_thermal` sets bit 11. Status bits outside mask 0x0B03 always read zero.
- R4: A write to status (index 0) clears every bit in mask 0x0B03 that is written as 1. Bits written as 0 keep their value.
- R5: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: The error address register (index 2) returns captured address bits 31:7 in bits 31:7, zero in bits 6:1 and the channel in bit 0. The extended register (index 3) returns address bit 32 in bit 0, other bits zero. The syndrome register (index 4) returns the syndrome in bits 7:0.
- R7: A correctable event captures address, channel and syndrome only while no status bit in mask 0x0B03 is set; otherwise the capture is unchanged.
- R8: An uncorrectable event captures address, channel and syndrome whenever status bit 1 is clear, overwriting any correctable record. While bit 1 is set, the first uncorrectable record is kept.
- R9: The command register (index 1) stores written bits 0, 1, 8, 9 and 11 and reads zero elsewhere. `serr` is high exactly when some status bit and the same command bit are both set. It falls in the cycle after the enabling status or command bits are cleared.
- R10: Writes to indices 2, 3, 4 and 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | One-cycle ECC error event strobe |
| ev_multi | input | 1 | 1 = uncorrectable, 0 = correctable |
| ev_addr | input | 33 | Physical address of the failing access |
| ev_chan | input | 1 | Channel of the failing access |
| ev_syn | input | 8 | ECC syndrome |
| ev_thermal | input | 1 | Thermal sensor event pulse |
| ev_lock | input | 1 | Locked access to non-memory space pulse |
| ev_refto | input | 1 | Refresh timeout pulse |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| serr | output | 1 | System-error level output |

## Verification
The properties assume that `serr` can fall only because of a register write. They also assume that each event input is a synchronous pulse that stays free of X while reset is released. The stimulus drives every input on the falling clock edge and holds it for one full cycle. It keeps the event inputs low during reset, so no flag is ever set without a traced cause. The bench checks capture ordering with deliberate sequences of correctable and uncorrectable events. It also sweeps every flag source against the command settings and every clear pattern over the five flags.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
  localparam int STS_W = 16;
  localparam logic [STS_W-1:0] ERR_MASK = 16'h0B03;
  localparam int BIT_CE    = 0;
  localparam int BIT_UE    = 1;
  localparam int BIT_REFTO = 8;
  localparam int BIT_LOCK  = 9;
  localparam int BIT_THERM = 11;

  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_CMD    = 3'd1,
    RA_ADDR   = 3'd2,
    RA_EXT    = 3'd3,
    RA_SYN    = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/ecc_log_flags.sv
module ecc_log_flags
  import ecc_err_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_vec,
  input  logic [STS_W-1:0] clr_vec,
  input  logic             cmd_we,
  input  logic [STS_W-1:0] cmd_wdata,
  output logic [STS_W-1:0] sts_q,
  output logic [STS_W-1:0] cmd_q
);
  logic [STS_W-1:0] cmd_d;
  logic             unused_rsvd;

  assign unused_rsvd = ^{set_vec & ~ERR_MASK, clr_vec & ~ERR_MASK, cmd_wdata & ~ERR_MASK};
  assign cmd_d = cmd_wdata & ERR_MASK;

  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    if (ERR_MASK[i]) begin : g_live
      logic sts_en, sts_d;
      always_comb begin
        sts_en = set_vec[i] | clr_vec[i];
        sts_d  = set_vec[i] | (sts_q[i] & ~clr_vec[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sts_q[i] <= 1'b0;
        else if (sts_en) sts_q[i] <= sts_d;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmd_q[i] <= 1'b0;
        else if (cmd_we) cmd_q[i] <= cmd_d[i];
      end
    end else begin : g_rsvd
      assign sts_q[i] = 1'b0;
      assign cmd_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W = 33,
  parameter int SYN_W  = 8,
  parameter int GRAIN  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_valid,
  input  logic                  ev_multi,
  input  logic [ADDR_W-1:0]     ev_addr,
  input  logic                  ev_chan,
  input  logic [SYN_W-1:0]      ev_syn,
  input  logic                  any_err,
  input  logic                  ue_flag,
  output logic [ADDR_W-1:GRAIN] cap_addr,
  output logic                  cap_chan,
  output logic [SYN_W-1:0]      cap_syn
);
  logic cap_en;
  logic unused_low;

  assign unused_low = ^ev_addr[GRAIN-1:0];

  // Uncorrectable wins over a correctable record; correctable only fills an empty log.
  always_comb begin
    cap_en = ev_valid & (ev_multi ? ~ue_flag : ~any_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_chan <= 1'b0;
      cap_syn  <= '0;
    end else if (cap_en) begin
      cap_addr <= ev_addr[ADDR_W-1:GRAIN];
      cap_chan <= ev_chan;
      cap_syn  <= ev_syn;
    end
  end
endmodule

// File: rtl/ecc_log_rdmux.sv
module ecc_log_rdmux
  import ecc_err_log_pkg::*;
#(
  parameter int ADDR_W = 33,
  parameter int SYN_W  = 8,
  parameter int GRAIN  = 7,
  parameter int RD_W   = 32
) (
  input  logic [2:0]            reg_addr,
  input  logic [STS_W-1:0]      sts_q,
  input  logic [STS_W-1:0]      cmd_q,
  input  logic [ADDR_W-1:GRAIN] cap_addr,
  input  logic                  cap_chan,
  input  logic [SYN_W-1:0]      cap_syn,
  output logic [RD_W-1:0]       reg_rdata
);
  localparam int EXT_W = ADDR_W - 32;

  always_comb begin
    case (reg_addr)
      RA_STATUS: reg_rdata = {{(RD_W-STS_W){1'b0}}, sts_q};
      RA_CMD:    reg_rdata = {{(RD_W-STS_W){1'b0}}, cmd_q};
      RA_ADDR:   reg_rdata = {cap_addr[31:GRAIN], {(GRAIN-1){1'b0}}, cap_chan};
      RA_EXT:    reg_rdata = {{(RD_W-EXT_W){1'b0}}, cap_addr[ADDR_W-1:32]};
      RA_SYN:    reg_rdata = {{(RD_W-SYN_W){1'b0}}, cap_syn};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_log_pkg::*;
#(
  parameter int ADDR_W = 33,
  parameter int SYN_W  = 8,
  parameter int GRAIN  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_multi,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_chan,
  input  logic [SYN_W-1:0]  ev_syn,
  input  logic              ev_thermal,
  input  logic              ev_lock,
  input  logic              ev_refto,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [STS_W-1:0]  reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              serr
);
  logic [STS_W-1:0]      set_vec, clr_vec, sts_q, cmd_q;
  logic [ADDR_W-1:GRAIN] cap_addr;
  logic                  cap_chan, cmd_we;
  logic [SYN_W-1:0]      cap_syn;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_CE]    = ev_valid & ~ev_multi;
    set_vec[BIT_UE]    = ev_valid &  ev_multi;
    set_vec[BIT_REFTO] = ev_refto;
    set_vec[BIT_LOCK]  = ev_lock;
    set_vec[BIT_THERM] = ev_thermal;
    clr_vec = (reg_wr && reg_addr == RA_STATUS) ? (reg_wdata & ERR_MASK) : '0;
    cmd_we  = reg_wr && reg_addr == RA_CMD;
  end

  ecc_log_flags flags_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .cmd_we(cmd_we), .cmd_wdata(reg_wdata), .sts_q(sts_q), .cmd_q(cmd_q)
  );

  ecc_log_capture #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .GRAIN(GRAIN)) cap_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_multi(ev_multi),
    .ev_addr(ev_addr), .ev_chan(ev_chan), .ev_syn(ev_syn),
    .any_err(|(sts_q & ERR_MASK)), .ue_flag(sts_q[BIT_UE]),
    .cap_addr(cap_addr), .cap_chan(cap_chan), .cap_syn(cap_syn)
  );

  ecc_log_rdmux #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .GRAIN(GRAIN)) mux_i (
    .reg_addr(reg_addr), .sts_q(sts_q), .cmd_q(cmd_q), .cap_addr(cap_addr),
    .cap_chan(cap_chan), .cap_syn(cap_syn), .reg_rdata(reg_rdata)
  );

  assign serr = |(sts_q & cmd_q & ERR_MASK);
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
  import ecc_err_log_pkg::*;
#(
  parameter int ADDR_W = 33,
  parameter int GRAIN  = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ev_valid,
  input logic                  ev_multi,
  input logic [ADDR_W-1:0]     ev_addr,
  input logic                  reg_wr,
  input logic [2:0]            reg_addr,
  input logic [STS_W-1:0]      reg_wdata,
  input logic [STS_W-1:0]      sts_q,
  input logic [ADDR_W-1:GRAIN] cap_addr,
  input logic                  serr
);
  // R2
  ue_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_multi |=> sts_q[BIT_UE]);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_multi |=> sts_q[BIT_CE]);

  // R4
  w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[BIT_UE] && !(reg_wr && reg_addr == RA_STATUS && reg_wdata[BIT_UE]) |=> sts_q[BIT_UE]);

  // R7
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_multi && (|(sts_q & ERR_MASK)) |=> $stable(cap_addr));

  // R8
  ue_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_multi && !sts_q[BIT_UE] |=> cap_addr == $past(ev_addr[ADDR_W-1:GRAIN]));

  // R9
  serr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(serr) |-> $past(reg_wr));
endmodule

bind ecc_err_log ecc_err_log_chk #(.ADDR_W(ADDR_W), .GRAIN(GRAIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_multi(ev_multi),
  .ev_addr(ev_addr), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .sts_q(sts_q), .cap_addr(cap_addr), .serr(serr)
);

// File: tb/ecc_err_log_tb_top.sv
`timescale 1ns/1ps
module ecc_err_log_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 0, ev_multi = 0, ev_chan = 0;
  logic [32:0] ev_addr = '0;
  logic [7:0]  ev_syn = '0;
  logic        ev_thermal = 0, ev_lock = 0, ev_refto = 0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        serr;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_sts = '0, m_cmd = '0;
  logic [32:0] m_cap = '0;
  logic        m_chan = 0;
  logic [7:0]  m_syn = '0;
  localparam logic [15:0] MASK = 16'h0B03;
  localparam logic [15:0] SRC_BIT [5] = '{16'h0001, 16'h0002, 16'h0100, 16'h0200, 16'h0800};

  always #4 clk = ~clk;

  ecc_err_log dut_i (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    rd(3'd0, d); check({req, " status"}, d, {16'b0, m_sts});
    rd(3'd1, d); check({req, " cmd"}, d, {16'b0, m_cmd});
    rd(3'd2, d); check({req, " addr"}, d, {m_cap[31:7], 6'b0, m_chan});
    rd(3'd3, d); check({req, " ext"}, d, {31'b0, m_cap[32]});
    rd(3'd4, d); check({req, " syn"}, d, {24'b0, m_syn});
    check({req, " serr"}, {31'b0, serr}, {31'b0, |(m_sts & m_cmd & MASK)});
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    if (a == 3'd0) m_sts = m_sts & ~(d & MASK);
    if (a == 3'd1) m_cmd = d & MASK;
  endtask

  task automatic ev(input logic multi, input logic [32:0] a, input logic c, input logic [7:0] s);
    @(negedge clk); ev_valid = 1; ev_multi = multi; ev_addr = a; ev_chan = c; ev_syn = s;
    @(negedge clk); ev_valid = 0;
    if (multi ? !m_sts[1] : (m_sts & MASK) == 0) begin
      m_cap = a; m_chan = c; m_syn = s;
    end
    m_sts[multi ? 1 : 0] = 1'b1;
  endtask

  task automatic side(input int which);
    @(negedge clk);
    ev_refto = (which == 2); ev_lock = (which == 3); ev_thermal = (which == 4);
    @(negedge clk); ev_refto = 0; ev_lock = 0; ev_thermal = 0;
    m_sts = m_sts | SRC_BIT[which];
  endtask

  task automatic source(input int s, input int seed);
    logic [32:0] a;
    a = {seed[0], 32'h9E3779B9 * (seed + 1)};
    if (s < 2) ev(s == 1, a, seed[1], 8'(seed * 37 + 5));
    else side(s);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] cmds [3];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R2 R3 R9: every flag source under three command settings
    for (int s = 0; s < 5; s++) begin
      cmds = '{16'h0000, SRC_BIT[s], 16'hFFFF};
      for (int k = 0; k < 3; k++) begin
        wr(3'd1, cmds[k]);
        source(s, s * 3 + k);
        check_all(s < 2 ? "R2 R9" : "R3 R9");
        wr(3'd0, 16'hFFFF);
        check_all("R4 R9 drop");
      end
    end

    // R4 R3: clear-pattern sweep over the five flags, reserved bits written too
    wr(3'd1, 16'h0000);
    for (int p = 0; p < 32; p++) begin
      logic [15:0] pat;
      for (int s = 0; s < 5; s++) source(s, p + s);
      pat = 16'hF4FC;
      for (int s = 0; s < 5; s++) if (p[s]) pat = pat | SRC_BIT[s];
      wr(3'd0, pat);
      check_all("R4 R3");
      wr(3'd0, 16'hFFFF);
    end

    // R6 R7 R8: capture ordering
    ev(1'b0, 33'h1_2345_6789, 1'b1, 8'h5A); check_all("R6 R7 first CE");
    ev(1'b0, 33'h0_ABCD_EF00, 1'b0, 8'h11); check_all("R7 CE kept");
    ev(1'b1, 33'h0_7654_3210, 1'b0, 8'hC3); check_all("R8 UE over CE");
    ev(1'b0, 33'h1_FFFF_FFFF, 1'b1, 8'h22); check_all("R7 CE under UE");
    ev(1'b1, 33'h1_0000_0080, 1'b1, 8'h99); check_all("R8 UE kept");
    wr(3'd0, 16'h0B03);
    ev(1'b1, 33'h1_8000_0FFF, 1'b1, 8'h7E); check_all("R8 UE on empty");
    wr(3'd0, 16'h0B03);
    side(4);
    ev(1'b0, 33'h0_1111_1111, 1'b1, 8'h33); check_all("R7 CE blocked by thermal");
    wr(3'd0, 16'h0B03);

    // R5: correctable event and clear of bits 1:0 in one cycle
    ev(1'b0, 33'h0_2222_2200, 1'b0, 8'h44);
    @(negedge clk);
    ev_valid = 1; ev_multi = 0; ev_addr = 33'h1_3333_3300; ev_syn = 8'h55;
    reg_addr = 3'd0; reg_wdata = 16'h0003; reg_wr = 1;
    @(negedge clk); ev_valid = 0; reg_wr = 0;
    m_sts = 16'h0001;
    check_all("R5");

    // R10: writes to capture and unmapped indices
    for (int a = 2; a < 8; a++) begin
      wr(3'(a), 16'hFFFF);
      check_all("R10");
    end

    // R9: reserved command bits read zero
    wr(3'd1, 16'hFFFF);
    check_all("R9 cmd mask");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule